// File: doc/BRIEF.md
# Exception Control Register File

This block keeps the exception state of a small 32-bit RISC core. It has four registers. The faulting-address register records the memory address of an illegal load or store. The status register holds an eight-bit interrupt mask and a three-deep stack of (mode, interrupt-enable) pairs. The cause register holds the pending interrupt flags and the code of the last exception. The return-address register holds the program counter of the instruction that faulted.

The core signals three kinds of event. It raises `exc_valid` with a code, PC and address when an instruction faults. It raises `rfe_valid` when the handler returns. It uses the move port to read or write a register by number. The block pushes or pops the mode stack on these events, records the fault details and combines the pending flags with the mask to request an interrupt. The registers are private to kernel mode. A move attempted in user mode does not touch the registers. Instead it raises a coprocessor-unusable exception.

Top module: `exc_ctrl_regs`

## Requirements
- R1: Register number 8 selects the faulting address, 12 selects status, 13 selects cause and 14 selects the return address. In kernel mode `rd_data` shows the selected register in the same cycle. Any other number reads zero.
- R2: On an exception the stack pushes: status[5:4] takes the old status[3:2], status[3:2] takes the old status[1:0], and status[1:0] becomes 00 (kernel mode, interrupts off). Each pair is {mode, enable}.
- R3: On a return the stack pops: status[1:0] takes status[3:2], status[3:2] takes status[5:4], and status[5:4] keeps its value.
- R4: On an exception, cause[6:2] loads the 5-bit code and the return-address register loads `exc_pc`. Both take effect at the next clock edge.
- R5: The faulting-address register loads `exc_addr` only for code 4 (illegal load address) or code 5 (illegal store address). For any other code it keeps its value.
- R6: cause[15:10] shows `irq_lines[5:0]` one clock edge after the lines are sampled. The flags stay set as long as the lines stay high. A code-0 exception keeps them.
- R7: `irq_req` is 1 exactly when status[0] is 1 and at least one bit of (cause[15:8] AND status[15:8]) is set.
- R8: `user_mode` equals status[1]. A 1 means user mode.
- R9: Writes in kernel mode behave as follows:
  - Status takes bits 15:8 and 5:0.
  - Cause takes only bits 9:8 (the software interrupt flags).
  - The return-address register takes all 32 bits.
  - The faulting-address register ignores writes.
  - All unused bits read zero.
- R10: In user mode `rd_data` is zero. A move attempt in user mode leaves the registers unwritten and takes an exception with code 11, with `mv_pc` as the return address.
- R11: Priority within one cycle runs from `exc_valid`, to a user-mode move fault, to `rfe_valid`, to a kernel move write. An event that loses in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception strobe |
| exc_code | input | 5 | Exception code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_addr | input | 32 | Faulting memory address |
| irq_lines | input | 6 | External interrupt lines, levels 2 to 7 |
| rfe_valid | input | 1 | Return-from-exception strobe |
| mv_valid | input | 1 | Register move strobe |
| mv_write | input | 1 | 1 = write the register, 0 = read it |
| mv_regnum | input | 5 | Register number |
| mv_wdata | input | 32 | Write data |
| mv_pc | input | 32 | PC of the move instruction |
| irq_req | output | 1 | Masked interrupt request |
| user_mode | output | 1 | Current mode, 1 = user |
| rd_data | output | 32 | Read data |

## Verification
`rd_data`, `irq_req` and `user_mode` are combinational from the registers, so they respond in the same cycle that a register or `mv_regnum` changes. Every register update, and the sampling of `irq_lines`, lands at the first rising edge after the stimulus. The bench drives each stimulus 2 ns after a rising edge and holds it across exactly one edge. It then reads the results 2 ns after that edge, with all strobes low. To check the one-edge sampling delay, the bench also reads the cause register before the edge and expects the old value.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int HW_IRQS   = 6;
  localparam int SW_IRQS   = 2;
  localparam int CODE_W    = 5;
  localparam int REGSEL_W  = 5;

  // register numbers decoded by the move port
  localparam logic [REGSEL_W-1:0] SEL_BADADDR = 5'd8;
  localparam logic [REGSEL_W-1:0] SEL_STATUS  = 5'd12;
  localparam logic [REGSEL_W-1:0] SEL_CAUSE   = 5'd13;
  localparam logic [REGSEL_W-1:0] SEL_RETPC   = 5'd14;

  // exception codes
  localparam logic [CODE_W-1:0] CODE_IRQ      = 5'd0;
  localparam logic [CODE_W-1:0] CODE_BAD_LOAD = 5'd4;
  localparam logic [CODE_W-1:0] CODE_BAD_STOR = 5'd5;
  localparam logic [CODE_W-1:0] CODE_IFETCH   = 5'd6;
  localparam logic [CODE_W-1:0] CODE_DBUS     = 5'd7;
  localparam logic [CODE_W-1:0] CODE_SYSCALL  = 5'd8;
  localparam logic [CODE_W-1:0] CODE_BREAK    = 5'd9;
  localparam logic [CODE_W-1:0] CODE_ILLEGAL  = 5'd10;
  localparam logic [CODE_W-1:0] CODE_NO_COP   = 5'd11;
  localparam logic [CODE_W-1:0] CODE_OVERFLOW = 5'd12;

  // field placement inside the status and cause words
  localparam int MASK_LSB  = 8;
  localparam int MASK_BITS = HW_IRQS + SW_IRQS;
  localparam int CODE_LSB  = 2;
  localparam int PEND_LSB  = 8;

  typedef struct packed {
    logic take;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   pc;
    logic              load_bad;
  } exc_event_t;
endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack
  import exc_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] status_o,
  output logic            mode_cur,
  output logic            ie_cur
);
  localparam int STACK_W = 2 * DEPTH;

  logic [MASK_BITS-1:0] mask_q, mask_d;
  logic [STACK_W-1:0]   stack_q, stack_d;

  // next state: push beats pop beats software write
  always_comb begin
    mask_d  = mask_q;
    stack_d = stack_q;
    if (push) begin
      stack_d = {stack_q[STACK_W-3:0], 2'b00};
    end else if (pop) begin
      stack_d = {stack_q[STACK_W-1 -: 2], stack_q[STACK_W-1:2]};
    end else if (wr_en) begin
      mask_d  = wdata[MASK_LSB +: MASK_BITS];
      stack_d = wdata[STACK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      stack_q <= '0;
    end else begin
      if (push || pop || wr_en) begin
        stack_q <= stack_d;
      end
      if (wr_en && !push && !pop) begin
        mask_q <= mask_d;
      end
    end
  end

  always_comb begin
    status_o = '0;
    status_o[MASK_LSB +: MASK_BITS] = mask_q;
    status_o[STACK_W-1:0]           = stack_q;
  end

  assign ie_cur   = stack_q[0];
  assign mode_cur = stack_q[1];
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [CODE_W-1:0]  code,
  input  logic [HW_IRQS-1:0] irq_lines,
  input  logic               wr_en,
  input  logic [XLEN-1:0]    wdata,
  output logic [XLEN-1:0]    cause_o,
  output logic [MASK_BITS-1:0] pend_o
);
  logic [HW_IRQS-1:0] hw_q;
  logic [SW_IRQS-1:0] sw_q, sw_d;
  logic [CODE_W-1:0]  code_q, code_d;

  always_comb begin
    code_d = code_q;
    sw_d   = sw_q;
    if (take) begin
      code_d = code;
    end else if (wr_en) begin
      sw_d = wdata[PEND_LSB +: SW_IRQS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q   <= '0;
      sw_q   <= '0;
      code_q <= '0;
    end else begin
      hw_q <= irq_lines;
      if (take) begin
        code_q <= code_d;
      end
      if (wr_en && !take) begin
        sw_q <= sw_d;
      end
    end
  end

  assign pend_o = {hw_q, sw_q};

  always_comb begin
    cause_o = '0;
    cause_o[PEND_LSB +: MASK_BITS] = pend_o;
    cause_o[CODE_LSB +: CODE_W]    = code_q;
  end
endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [XLEN-1:0] pc,
  input  logic            load_bad,
  input  logic [XLEN-1:0] addr,
  input  logic            retpc_wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] retpc_o,
  output logic [XLEN-1:0] bad_o
);
  logic [XLEN-1:0] retpc_q, retpc_d;
  logic [XLEN-1:0] bad_q;
  logic            bad_en;

  always_comb begin
    retpc_d = retpc_q;
    if (take) begin
      retpc_d = pc;
    end else if (retpc_wr) begin
      retpc_d = wdata;
    end
  end

  assign bad_en = take && load_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retpc_q <= '0;
      bad_q   <= '0;
    end else begin
      if (take || retpc_wr) begin
        retpc_q <= retpc_d;
      end
      if (bad_en) begin
        bad_q <= addr;
      end
    end
  end

  assign retpc_o = retpc_q;
  assign bad_o   = bad_q;
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter int STACK_DEPTH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_valid,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [XLEN-1:0]     exc_pc,
  input  logic [XLEN-1:0]     exc_addr,
  input  logic [HW_IRQS-1:0]  irq_lines,
  input  logic                rfe_valid,
  input  logic                mv_valid,
  input  logic                mv_write,
  input  logic [REGSEL_W-1:0] mv_regnum,
  input  logic [XLEN-1:0]     mv_wdata,
  input  logic [XLEN-1:0]     mv_pc,
  output logic                irq_req,
  output logic                user_mode,
  output logic [XLEN-1:0]     rd_data
);
  logic [XLEN-1:0]      status_q, cause_q, retpc_q, bad_q;
  logic [MASK_BITS-1:0] pend;
  logic                 mode_cur, ie_cur;
  logic                 kernel;
  logic                 mv_fault, rfe_go, wr_go;
  logic                 wr_status, wr_cause, wr_retpc;
  exc_event_t           ev;

  assign kernel   = !mode_cur;
  assign mv_fault = mv_valid && !kernel && !exc_valid;

  // event selection: external exception, then move fault
  always_comb begin
    ev.take     = exc_valid || mv_fault;
    ev.code     = exc_valid ? exc_code : CODE_NO_COP;
    ev.pc       = exc_valid ? exc_pc : mv_pc;
    ev.load_bad = exc_valid &&
                  ((exc_code == CODE_BAD_LOAD) || (exc_code == CODE_BAD_STOR));
  end

  assign rfe_go    = rfe_valid && !ev.take;
  assign wr_go     = mv_valid && mv_write && kernel && !ev.take && !rfe_valid;
  assign wr_status = wr_go && (mv_regnum == SEL_STATUS);
  assign wr_cause  = wr_go && (mv_regnum == SEL_CAUSE);
  assign wr_retpc  = wr_go && (mv_regnum == SEL_RETPC);

  exc_status_stack #(.DEPTH(STACK_DEPTH)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ev.take),
    .pop      (rfe_go),
    .wr_en    (wr_status),
    .wdata    (mv_wdata),
    .status_o (status_q),
    .mode_cur (mode_cur),
    .ie_cur   (ie_cur)
  );

  exc_cause_reg u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ev.take),
    .code      (ev.code),
    .irq_lines (irq_lines),
    .wr_en     (wr_cause),
    .wdata     (mv_wdata),
    .cause_o   (cause_q),
    .pend_o    (pend)
  );

  exc_addr_regs u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (ev.take),
    .pc       (ev.pc),
    .load_bad (ev.load_bad),
    .addr     (exc_addr),
    .retpc_wr (wr_retpc),
    .wdata    (mv_wdata),
    .retpc_o  (retpc_q),
    .bad_o    (bad_q)
  );

  assign irq_req   = ie_cur && |(pend & status_q[MASK_LSB +: MASK_BITS]);
  assign user_mode = mode_cur;

  always_comb begin
    rd_data = '0;
    if (kernel) begin
      case (mv_regnum)
        SEL_BADADDR: rd_data = bad_q;
        SEL_STATUS:  rd_data = status_q;
        SEL_CAUSE:   rd_data = cause_q;
        SEL_RETPC:   rd_data = retpc_q;
        default:     rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk
  import exc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic [XLEN-1:0]   exc_pc,
  input logic              rfe_valid,
  input logic              mv_valid,
  input logic              user_mode,
  input logic              irq_req,
  input logic [XLEN-1:0]   status_q,
  input logic [XLEN-1:0]   cause_q,
  input logic [XLEN-1:0]   retpc_q,
  input logic [XLEN-1:0]   bad_q
);
  p_push_stack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (status_q[1:0] == 2'b00) && (status_q[5:2] == $past(status_q[3:0])));

  p_pop_stack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_valid && !exc_valid && !(mv_valid && user_mode)) |=>
      (status_q[3:0] == $past(status_q[5:2])) && (status_q[5:4] == $past(status_q[5:4])));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (retpc_q == $past(exc_pc)) && (cause_q[6:2] == $past(exc_code)));

  p_bad_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && (exc_code != 5'd4) && (exc_code != 5'd5)) |=> $stable(bad_q));

  p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> status_q[0]);

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[31:16] == 16'h0) && (status_q[7:6] == 2'b00) &&
    (cause_q[31:16] == 16'h0) && (cause_q[7] == 1'b0) && (cause_q[1:0] == 2'b00));

  p_user_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && user_mode && !exc_valid) |=> (cause_q[6:2] == 5'd11) && !user_mode);
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_valid (exc_valid),
  .exc_code  (exc_code),
  .exc_pc    (exc_pc),
  .rfe_valid (rfe_valid),
  .mv_valid  (mv_valid),
  .user_mode (user_mode),
  .irq_req   (irq_req),
  .status_q  (status_q),
  .cause_q   (cause_q),
  .retpc_q   (retpc_q),
  .bad_q     (bad_q)
);

// File: tb/exc_ctrl_regs_tb.sv
module exc_ctrl_regs_tb_top;
  logic        clk;
  logic        rst_n;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic [31:0] exc_pc, exc_addr;
  logic [5:0]  irq_lines;
  logic        rfe_valid, mv_valid, mv_write;
  logic [4:0]  mv_regnum;
  logic [31:0] mv_wdata, mv_pc;
  logic        irq_req, user_mode;
  logic [31:0] rd_data;

  int n_total = 0;
  int n_bad   = 0;
  bit finished = 0;

  exc_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_addr(exc_addr), .irq_lines(irq_lines),
    .rfe_valid(rfe_valid), .mv_valid(mv_valid), .mv_write(mv_write),
    .mv_regnum(mv_regnum), .mv_wdata(mv_wdata), .mv_pc(mv_pc),
    .irq_req(irq_req), .user_mode(user_mode), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    exc_valid = 0; rfe_valid = 0; mv_valid = 0; mv_write = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
    clear_strobes();
  endtask

  task automatic rd(input logic [4:0] r, output logic [31:0] d);
    mv_regnum = r; #1; d = rd_data;
  endtask

  task automatic kwrite(input logic [4:0] r, input logic [31:0] d);
    mv_valid = 1; mv_write = 1; mv_regnum = r; mv_wdata = d; tick();
  endtask

  task automatic take(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] a);
    exc_valid = 1; exc_code = c; exc_pc = pc; exc_addr = a; tick();
  endtask

  task automatic do_rfe();
    rfe_valid = 1; tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'd12, d); check("R1 status reset", d, 32'h0);
    rd(5'd13, d); check("R1 cause reset", d, 32'h0);
    rd(5'd14, d); check("R1 retpc reset", d, 32'h0);
    rd(5'd8,  d); check("R1 badaddr reset", d, 32'h0);
    check("R8 reset kernel", {31'b0, user_mode}, 32'h0);
    check("R7 reset irq", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_user_fault();
    logic [31:0] d;
    kwrite(5'd12, 32'hFFFF_FFFF);
    check("R8 user mode after write", {31'b0, user_mode}, 32'h1);
    rd(5'd12, d); check("R10 user read zero", d, 32'h0);
    mv_valid = 1; mv_write = 1; mv_regnum = 5'd13; mv_wdata = 32'hFFFF_FFFF; mv_pc = 32'h100;
    tick();
    check("R10 back in kernel", {31'b0, user_mode}, 32'h0);
    rd(5'd12, d); check("R9 R2 status after fault", d, 32'h0000_FF3C);
    rd(5'd13, d); check("R10 cause code 11, no sw write", d, 32'h0000_002C);
    rd(5'd14, d); check("R10 retpc = mv_pc", d, 32'h100);
  endtask

  task automatic t_stack();
    logic [31:0] d;
    kwrite(5'd12, 32'h0000_AB24);
    rd(5'd12, d); check("R9 status write", d, 32'h0000_AB24);
    take(5'd9, 32'h200, 32'h55);
    rd(5'd12, d); check("R2 push", d, 32'h0000_AB10);
    rd(5'd13, d); check("R4 cause code 9", d, 32'h0000_0024);
    rd(5'd14, d); check("R4 retpc", d, 32'h200);
    rd(5'd8, d);  check("R5 bad kept on code 9", d, 32'h0);
    do_rfe();
    rd(5'd12, d); check("R3 pop one", d, 32'h0000_AB14);
    do_rfe();
    rd(5'd12, d); check("R3 pop two", d, 32'h0000_AB15);
    check("R7 no pending no irq", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_badaddr();
    logic [31:0] d;
    take(5'd4, 32'h300, 32'hDEAD_0004);
    rd(5'd8, d); check("R5 load on code 4", d, 32'hDEAD_0004);
    take(5'd5, 32'h304, 32'hBEEF_0008);
    rd(5'd8, d); check("R5 load on code 5", d, 32'hBEEF_0008);
    take(5'd7, 32'h308, 32'h0000_1234);
    rd(5'd8, d); check("R5 kept on code 7", d, 32'hBEEF_0008);
  endtask

  task automatic t_soft_irq();
    logic [31:0] d;
    kwrite(5'd12, 32'h0);
    kwrite(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, d); check("R9 cause only sw bits", d, 32'h0000_031C);
    kwrite(5'd12, 32'h0000_0301);
    check("R7 soft irq enabled", {31'b0, irq_req}, 32'h1);
    kwrite(5'd12, 32'h0000_0300);
    check("R7 ie off", {31'b0, irq_req}, 32'h0);
    kwrite(5'd12, 32'h0000_0001);
    check("R7 masked", {31'b0, irq_req}, 32'h0);
    kwrite(5'd13, 32'h0);
    rd(5'd13, d); check("R9 cause sw cleared", d, 32'h0000_001C);
  endtask

  task automatic t_hw_irq();
    logic [31:0] d;
    kwrite(5'd12, 32'h0000_1001);
    irq_lines = 6'b000100;
    rd(5'd13, d); check("R6 not yet sampled", d, 32'h0000_001C);
    tick();
    rd(5'd13, d); check("R6 sampled after edge", d, 32'h0000_101C);
    check("R7 hw irq", {31'b0, irq_req}, 32'h1);
    kwrite(5'd12, 32'h0000_0801);
    check("R7 hw irq masked", {31'b0, irq_req}, 32'h0);
    kwrite(5'd12, 32'h0000_1001);
    take(5'd0, 32'h400, 32'h0);
    rd(5'd13, d); check("R6 R4 code 0 keeps pending", d, 32'h0000_1000);
    rd(5'd12, d); check("R2 push from 01", d, 32'h0000_1004);
    check("R7 entry disables irq", {31'b0, irq_req}, 32'h0);
    irq_lines = 6'b0;
    tick();
    rd(5'd13, d); check("R6 line dropped", d, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    kwrite(5'd12, 32'h0000_0004);
    exc_valid = 1; exc_code = 5'd12; exc_pc = 32'h500; exc_addr = 32'h9;
    rfe_valid = 1; mv_valid = 1; mv_write = 1; mv_regnum = 5'd12; mv_wdata = 32'hFFFF;
    tick();
    rd(5'd12, d); check("R11 exception wins", d, 32'h0000_0010);
    rd(5'd13, d); check("R11 cause code 12", d, 32'h0000_0030);
    rd(5'd14, d); check("R11 retpc", d, 32'h500);
    rfe_valid = 1; mv_valid = 1; mv_write = 1; mv_regnum = 5'd12; mv_wdata = 32'hFF3F;
    tick();
    rd(5'd12, d); check("R11 return beats write", d, 32'h0000_0014);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    kwrite(5'd14, 32'hCAFE_BABC);
    rd(5'd14, d); check("R9 retpc write", d, 32'hCAFE_BABC);
    kwrite(5'd8, 32'h0);
    rd(5'd8, d); check("R9 badaddr read-only", d, 32'hBEEF_0008);
    rd(5'd3, d); check("R1 unknown reg zero", d, 32'h0);
  endtask

  initial begin
    rst_n = 0; clear_strobes();
    exc_code = 0; exc_pc = 0; exc_addr = 0; irq_lines = 0;
    mv_regnum = 0; mv_wdata = 0; mv_pc = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_user_fault();
    t_stack();
    t_badaddr();
    t_soft_irq();
    t_hw_irq();
    t_priority();
    t_misc();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_total++; n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end
endmodule